// File: doc/BRIEF.md
# Packet Slot Segmentation Engine

The engine takes packets one byte per cycle from a valid/ready stream that marks the first and last byte. It stores each packet as a chain of fixed 128-byte slots and writes them through two word-wide memory write ports. The first slot of a packet always comes from a small fast on-chip pool. Every later slot comes from a much larger external pool. The first 32-bit word of each slot holds the index of the next slot in the chain. The payload bytes fill the remaining 31 words, so each slot carries 124 bytes.

When the last byte and the terminating link are written, the engine pushes a 128-bit descriptor into an internal FIFO, which downstream tasks drain. Slot indices come from two free stacks, one for each pool. An output stage hands consumed slots back through a return port. If a pool runs dry in the middle of a packet, the engine discards the rest of that packet, gives back every slot the packet already held, and counts the loss.

Top module: `slot_seg_engine`

## Requirements
- R1: After reset, `desc_valid` is 0, `drop_count` is 0, `in_ready` and `free_ready` are 1, and no memory write is issued.
- R2: Word 0 of each slot is the link word. Payload bytes fill words 1 to 31 in arrival order, with the earliest byte in bits 7:0 of each word, so each slot holds 124 bytes. Unused byte lanes of the last word are written as zero.
- R3: Slot indices form one space: the on-chip pool owns 0 to ONC_SLOTS-1 and the external pool owns the indices above. The first slot is on-chip and every later slot is external. The on-chip port address is slot*32+word. The external port address is (slot-ONC_SLOTS)*32+word.
- R4: The link word of a slot holds the index of the next slot of the same packet. The link word of the last slot is 32'hFFFF_FFFF.
- R5: Descriptor layout: bits [15:0] hold the first slot, [31:16] the byte length, [47:32] the slot count, and bit [48] is set when the packet uses more than one slot. All other bits are zero.
- R6: A descriptor appears only after all payload words and the terminating link are written. The slot count equals ceil(length/124): no slot is taken before a byte needs it.
- R7: Each pool is a LIFO stack. From reset, the on-chip pool hands out 0,1,2,… and the external pool hands out ONC_SLOTS, ONC_SLOTS+1,…. A returned index goes back to the pool its range belongs to and is the next one handed out.
- R8: If the needed pool is empty, the rest of the packet is accepted and discarded, all its slots return to their pools, no descriptor is produced, and `drop_count` rises by exactly 1.
- R9: While the descriptor FIFO is full, a finished packet holds `in_ready` low until space frees up. Descriptors leave in packet order.
- R10: `free_ready` is 0 while a packet is being received or finished, and also in any cycle where `in_valid` is 1.
- R11: A byte that arrives while idle without the start marker is accepted and discarded. It causes no write and no descriptor.
- R12: While `desc_valid` is 1 and `desc_ready` is 0, the descriptor stays valid and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | Marks first byte of a packet |
| in_eop | input | 1 | Marks last byte of a packet |
| onc_we | output | 1 | On-chip pool write enable |
| onc_addr | output | 10 | On-chip word address |
| onc_data | output | 32 | On-chip write data |
| ext_we | output | 1 | External pool write enable |
| ext_addr | output | 13 | External word address |
| ext_data | output | 32 | External write data |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Descriptor taken when high with desc_valid |
| desc_data | output | 128 | Packet descriptor |
| free_valid | input | 1 | Returned slot index valid |
| free_ready | output | 1 | Return accepted when high with free_valid |
| free_slot | input | 9 | Returned slot index |
| drop_count | output | 16 | Number of packets dropped for lack of slots |

## Verification
A corrupted free stack or a lost stack snapshot shows up on the next packet: its descriptor names a first slot, or its link words name external slots, different from the LIFO order that the returns so far imply. A wrong byte position or a wrong link shows up when the descriptor's chain is walked through the captured memory writes, a few cycles after the last byte. A wrong drop decision shows as a descriptor that should not exist, or as a `drop_count` that is off by one as soon as the dropped packet's last byte is taken.

// File: rtl/slot_seg_pkg.sv
package slot_seg_pkg;

    localparam int SLOT_BYTES     = 128;
    localparam int WORD_BYTES     = 4;
    localparam int WORDS_PER_SLOT = SLOT_BYTES / WORD_BYTES;
    localparam int PAYLOAD_BYTES  = SLOT_BYTES - WORD_BYTES;
    localparam int WIDX_W         = $clog2(WORDS_PER_SLOT) + 1;
    localparam logic [31:0] LINK_END = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        SEG_RECV,
        SEG_DROP,
        SEG_FIN,
        SEG_DESC
    } seg_state_e;

    typedef struct packed {
        logic [78:0] rsvd;
        logic        multi;
        logic [15:0] slot_cnt;
        logic [15:0] byte_len;
        logic [15:0] head_slot;
    } seg_desc_t;

    function automatic logic [31:0] lane_merge(input logic [31:0] acc,
                                               input logic [7:0]  b,
                                               input logic [1:0]  lane);
        return acc | ({24'b0, b} << {lane, 3'b000});
    endfunction

endpackage

// File: rtl/slot_free_stack.sv
module slot_free_stack #(
    parameter int DEPTH = 32,
    parameter int BASE  = 0,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             save,
    input  logic             restore,
    output logic [IDX_W-1:0] top_idx,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] entry [DEPTH];
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    saved;
    logic [AW-1:0]    top_ptr;

    assign empty   = (cnt == '0);
    assign top_ptr = AW'(cnt - 1'b1);
    assign top_idx = empty ? '0 : entry[top_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                entry[i] <= IDX_W'(BASE + DEPTH - 1 - i);
            end
            cnt   <= CW'(DEPTH);
            saved <= CW'(DEPTH);
        end else begin
            if (save) saved <= cnt;
            if (restore) begin
                cnt <= saved;
            end else if (pop) begin
                cnt <= cnt - 1'b1;
            end else if (push) begin
                entry[AW'(cnt)] <= push_idx;
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt < CW'(DEPTH)));

endmodule

// File: rtl/slot_desc_fifo.sv
module slot_desc_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          pop;

    assign out_valid = (cnt != '0);
    assign full      = (cnt == (AW+1)'(DEPTH));
    assign out_data  = store[rp];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                store[wp] <= push_data;
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    a_r9_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r12_desc_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/slot_seg_engine.sv
module slot_seg_engine
    import slot_seg_pkg::*;
#(
    parameter int ONC_SLOTS  = 32,
    parameter int EXT_SLOTS  = 256,
    parameter int DESC_DEPTH = 4,
    localparam int IDX_W   = $clog2(ONC_SLOTS + EXT_SLOTS),
    localparam int ONC_AW  = $clog2(ONC_SLOTS * WORDS_PER_SLOT),
    localparam int EXT_AW  = $clog2(EXT_SLOTS * WORDS_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              onc_we,
    output logic [ONC_AW-1:0] onc_addr,
    output logic [31:0]       onc_data,
    output logic              ext_we,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [31:0]       ext_data,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [127:0]      desc_data,
    input  logic              free_valid,
    output logic              free_ready,
    input  logic [IDX_W-1:0]  free_slot,
    output logic [15:0]       drop_count
);
    localparam logic [IDX_W-1:0]  ONC_LIM  = IDX_W'(ONC_SLOTS);
    localparam logic [WIDX_W-1:0] WORD_END = WIDX_W'(WORDS_PER_SLOT);

    seg_state_e        state;
    logic              cur_valid;
    logic [IDX_W-1:0]  cur_slot, head_slot;
    logic [WIDX_W-1:0] widx;
    logic [1:0]        boff;
    logic [31:0]       wbuf;
    logic [15:0]       byte_len, slot_cnt;

    logic need_first, need_next, take_byte, accept;
    logic onc_pop, ext_pop, onc_empty, ext_empty, snap, unwind;
    logic [IDX_W-1:0] onc_top, ext_top;
    logic free_take, push_onc, push_ext;
    logic fifo_full, fifo_push, drop_evt;
    logic [31:0] merged;
    seg_desc_t desc_n;

    logic              wr_req;
    logic [IDX_W-1:0]  wr_slot;
    logic [WIDX_W-1:0] wr_word;
    logic [31:0]       wr_dat;

    // ---------------- handshake decisions ----------------
    always_comb begin
        need_first = (state == SEG_RECV) && !cur_valid && in_valid && in_sop;
        need_next  = (state == SEG_RECV) && cur_valid && in_valid && (widx == WORD_END);
        in_ready   = ((state == SEG_RECV) &&
                      ((!cur_valid && !in_sop) || (cur_valid && widx != WORD_END)))
                     || (state == SEG_DROP);
        accept     = in_valid && in_ready;
        take_byte  = accept && (state == SEG_RECV) && cur_valid;
        onc_pop    = need_first && !onc_empty;
        ext_pop    = need_next && !ext_empty;
        snap       = onc_pop;
        unwind     = need_next && ext_empty;
        drop_evt   = (need_first && onc_empty) || unwind;
        fifo_push  = (state == SEG_DESC) && !fifo_full;
        free_ready = (state == SEG_RECV) && !cur_valid && !in_valid;
        free_take  = free_valid && free_ready;
        push_onc   = free_take && (free_slot < ONC_LIM);
        push_ext   = free_take && (free_slot >= ONC_LIM);
        merged     = lane_merge(wbuf, in_data, boff);
    end

    // ---------------- write request selection ----------------
    always_comb begin
        wr_req  = 1'b0;
        wr_slot = cur_slot;
        wr_word = '0;
        wr_dat  = '0;
        if (ext_pop) begin
            wr_req = 1'b1;
            wr_dat = 32'(ext_top);
        end else if (take_byte && (boff == 2'd3 || in_eop)) begin
            wr_req  = 1'b1;
            wr_word = widx;
            wr_dat  = merged;
        end else if (state == SEG_FIN) begin
            wr_req = 1'b1;
            wr_dat = LINK_END;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            onc_we   <= 1'b0;
            ext_we   <= 1'b0;
            onc_addr <= '0;
            ext_addr <= '0;
            onc_data <= '0;
            ext_data <= '0;
        end else begin
            onc_we   <= wr_req && (wr_slot < ONC_LIM);
            ext_we   <= wr_req && (wr_slot >= ONC_LIM);
            onc_addr <= ONC_AW'(int'(wr_slot) * WORDS_PER_SLOT + int'(wr_word));
            ext_addr <= EXT_AW'((int'(wr_slot) - ONC_SLOTS) * WORDS_PER_SLOT + int'(wr_word));
            onc_data <= wr_dat;
            ext_data <= wr_dat;
        end
    end

    // ---------------- packet state machine ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEG_RECV;
            cur_valid  <= 1'b0;
            cur_slot   <= '0;
            head_slot  <= '0;
            widx       <= WIDX_W'(1);
            boff       <= '0;
            wbuf       <= '0;
            byte_len   <= '0;
            slot_cnt   <= '0;
            drop_count <= '0;
        end else begin
            if (drop_evt) drop_count <= drop_count + 16'd1;
            case (state)
                SEG_RECV: begin
                    if (need_first) begin
                        if (onc_empty) begin
                            state <= SEG_DROP;
                        end else begin
                            cur_valid <= 1'b1;
                            cur_slot  <= onc_top;
                            head_slot <= onc_top;
                            byte_len  <= '0;
                            slot_cnt  <= 16'd1;
                            widx      <= WIDX_W'(1);
                            boff      <= '0;
                            wbuf      <= '0;
                        end
                    end else if (need_next) begin
                        if (ext_empty) begin
                            state     <= SEG_DROP;
                            cur_valid <= 1'b0;
                        end else begin
                            cur_slot <= ext_top;
                            slot_cnt <= slot_cnt + 16'd1;
                            widx     <= WIDX_W'(1);
                        end
                    end else if (take_byte) begin
                        byte_len <= byte_len + 16'd1;
                        if (boff == 2'd3 || in_eop) begin
                            wbuf <= '0;
                            boff <= '0;
                            widx <= widx + 1'b1;
                        end else begin
                            wbuf <= merged;
                            boff <= boff + 1'b1;
                        end
                        if (in_eop) state <= SEG_FIN;
                    end
                end
                SEG_DROP: if (accept && in_eop) state <= SEG_RECV;
                SEG_FIN:  state <= SEG_DESC;
                SEG_DESC: begin
                    if (!fifo_full) begin
                        state     <= SEG_RECV;
                        cur_valid <= 1'b0;
                    end
                end
                default: state <= SEG_RECV;
            endcase
        end
    end

    always_comb begin
        desc_n           = '0;
        desc_n.head_slot = 16'(head_slot);
        desc_n.byte_len  = byte_len;
        desc_n.slot_cnt  = slot_cnt;
        desc_n.multi     = (slot_cnt > 16'd1);
    end

    // ---------------- pools and descriptor queue ----------------
    slot_free_stack #(.DEPTH(ONC_SLOTS), .BASE(0), .IDX_W(IDX_W)) onc_pool_i (
        .clk(clk), .rst(rst), .pop(onc_pop), .push(push_onc), .push_idx(free_slot),
        .save(snap), .restore(unwind), .top_idx(onc_top), .empty(onc_empty));

    slot_free_stack #(.DEPTH(EXT_SLOTS), .BASE(ONC_SLOTS), .IDX_W(IDX_W)) ext_pool_i (
        .clk(clk), .rst(rst), .pop(ext_pop), .push(push_ext), .push_idx(free_slot),
        .save(snap), .restore(unwind), .top_idx(ext_top), .empty(ext_empty));

    slot_desc_fifo #(.DEPTH(DESC_DEPTH), .W(128)) desc_q_i (
        .clk(clk), .rst(rst), .push(fifo_push), .push_data(desc_n), .full(fifo_full),
        .out_valid(desc_valid), .out_ready(desc_ready), .out_data(desc_data));

    a_r8_drop_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count == $past(drop_count) ||
                  drop_count == $past(drop_count) + 16'd1));
    a_r6_desc_after_fin: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> $past(state) == SEG_FIN || $past(state) == SEG_DESC);

endmodule

// File: tb/slot_seg_engine_tb_top.sv
module slot_seg_engine_tb_top;
    localparam int ON = 4;
    localparam int EX = 8;
    localparam int IW = $clog2(ON + EX);
    localparam int OAW = $clog2(ON * 32);
    localparam int EAW = $clog2(EX * 32);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready;
    logic onc_we, ext_we;
    logic [OAW-1:0] onc_addr;
    logic [EAW-1:0] ext_addr;
    logic [31:0] onc_data, ext_data;
    logic desc_valid;
    logic desc_ready = 1'b0;
    logic [127:0] desc_data;
    logic free_valid = 1'b0;
    logic free_ready;
    logic [IW-1:0] free_slot = '0;
    logic [15:0] drop_count;

    int checks = 0;
    int bad = 0;
    int wr_cnt = 0;
    bit done = 0;

    logic [31:0] onc_mem [ON*32];
    logic [31:0] ext_mem [EX*32];

    always #10 clk = ~clk;

    slot_seg_engine #(.ONC_SLOTS(ON), .EXT_SLOTS(EX), .DESC_DEPTH(2)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .onc_we(onc_we), .onc_addr(onc_addr),
        .onc_data(onc_data), .ext_we(ext_we), .ext_addr(ext_addr), .ext_data(ext_data),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
        .free_valid(free_valid), .free_ready(free_ready), .free_slot(free_slot),
        .drop_count(drop_count));

    always @(negedge clk) begin
        if (onc_we) begin onc_mem[onc_addr] = onc_data; wr_cnt++; end
        if (ext_we) begin ext_mem[ext_addr] = ext_data; wr_cnt++; end
    end

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 7 + k * 13 + 1) & 255);
    endfunction

    function automatic logic [31:0] rd(int slot, int w);
        if (slot < ON) return onc_mem[slot*32 + w];
        return ext_mem[(slot - ON)*32 + w];
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_pkt(int len, int seed, bit with_sop, int probe);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (k == probe) begin
                in_valid = 1'b0;
                #1;
                chk(free_ready == 1'b0, "R10 free blocked mid-packet", free_ready, 0);
            end
            in_valid = 1'b1;
            in_data  = pat(seed, k);
            in_sop   = with_sop && (k == 0);
            in_eop   = (k == len - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic get_desc(output logic [127:0] d);
        @(negedge clk);
        while (!desc_valid) @(negedge clk);
        d = desc_data;
        desc_ready = 1'b1;
        @(posedge clk);
        #1 desc_ready = 1'b0;
    endtask

    task automatic free_one(int slot);
        @(negedge clk);
        free_valid = 1'b1;
        free_slot  = IW'(slot);
        #1;
        while (!free_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 free_valid = 1'b0;
    endtask

    task automatic chk_desc(logic [127:0] d, int first, int len, int cnt);
        chk(d[15:0] == 16'(first), "R5 first slot", d[15:0], first);
        chk(d[31:16] == 16'(len), "R5 byte length", d[31:16], len);
        chk(d[47:32] == 16'(cnt), "R6 slot count", d[47:32], cnt);
        chk(d[48] == (cnt > 1), "R5 multi flag", d[48], cnt > 1);
        chk(d[127:49] == '0, "R5 reserved zero", 0, 0);
    endtask

    task automatic walk(int first, int len, int seed);
        int s = first;
        int errs = 0;
        bit pool_ok = (first < ON);
        for (int k = 0; k < len; k++) begin
            if (k > 0 && k % 124 == 0) begin
                s = int'(rd(s, 0));
                if (s < ON || s >= ON + EX) pool_ok = 0;
            end
            if (8'(rd(s, 1 + (k % 124) / 4) >> (8 * (k % 4))) != pat(seed, k)) errs++;
        end
        chk(errs == 0, "R2 payload bytes", errs, 0);
        chk(pool_ok, "R3 pool placement", pool_ok, 1);
        chk(rd(s, 0) == 32'hFFFF_FFFF, "R4 null link", rd(s, 0), 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(desc_valid == 0, "R1 desc_valid", desc_valid, 0);
        chk(drop_count == 0, "R1 drop_count", drop_count, 0);
        chk(in_ready == 1, "R1 in_ready", in_ready, 1);
        chk(free_ready == 1, "R1 free_ready", free_ready, 1);
        chk(wr_cnt == 0, "R1 no writes", wr_cnt, 0);
    endtask

    task automatic t_stray();
        send_pkt(3, 9, 1'b0, -1);
        repeat (5) @(negedge clk);
        chk(wr_cnt == 0, "R11 stray bytes write nothing", wr_cnt, 0);
        chk(desc_valid == 0, "R11 stray bytes no descriptor", desc_valid, 0);
    endtask

    task automatic t_short();
        logic [127:0] d;
        send_pkt(10, 1, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 10, 1);
        walk(0, 10, 1);
        chk(rd(0, 3)[31:16] == 16'h0, "R2 unused lanes zero", rd(0, 3), 0);
        free_one(0);
    endtask

    task automatic t_multi();
        logic [127:0] d;
        send_pkt(300, 2, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 300, 3);
        chk(rd(0, 0) == 32'd4, "R4 link to first external", rd(0, 0), 4);
        chk(rd(4, 0) == 32'd5, "R7 external order", rd(4, 0), 5);
        walk(0, 300, 2);
        free_one(5); free_one(4); free_one(0);
    endtask

    task automatic t_boundary();
        logic [127:0] d;
        send_pkt(124, 3, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 124, 1);
        walk(0, 124, 3);
        free_one(0);
        send_pkt(125, 4, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 125, 2);
        walk(0, 125, 4);
        free_one(4); free_one(0);
    endtask

    task automatic t_lifo();
        logic [127:0] d;
        send_pkt(20, 5, 1'b1, 6);
        get_desc(d);
        chk_desc(d, 0, 20, 1);
        free_one(0);
        send_pkt(130, 6, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 130, 2);
        send_pkt(130, 7, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 1, 130, 2);
        chk(rd(1, 0) == 32'd5, "R7 second external slot", rd(1, 0), 5);
        free_one(4); free_one(0);
        send_pkt(130, 8, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 130, 2);
        chk(rd(0, 0) == 32'd4, "R7 returned slot reused", rd(0, 0), 4);
        walk(0, 130, 8);
        free_one(5); free_one(1); free_one(4); free_one(0);
    endtask

    task automatic t_drop_ext();
        logic [127:0] d;
        send_pkt(1240, 10, 1'b1, -1);
        repeat (4) @(negedge clk);
        chk(drop_count == 16'd1, "R8 drop counted", drop_count, 1);
        chk(desc_valid == 0, "R8 no descriptor for drop", desc_valid, 0);
        send_pkt(300, 11, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 300, 3);
        chk(rd(0, 0) == 32'd4, "R8 slots returned after drop", rd(0, 0), 4);
        walk(0, 300, 11);
        free_one(5); free_one(4); free_one(0);
    endtask

    task automatic t_drop_onc();
        logic [127:0] d;
        for (int p = 0; p < 4; p++) begin
            send_pkt(10, 20 + p, 1'b1, -1);
            get_desc(d);
            chk(d[15:0] == 16'(p), "R7 on-chip order", d[15:0], p);
        end
        send_pkt(10, 30, 1'b1, -1);
        repeat (4) @(negedge clk);
        chk(drop_count == 16'd2, "R8 on-chip empty drop", drop_count, 2);
        chk(desc_valid == 0, "R8 no descriptor", desc_valid, 0);
        free_one(3); free_one(2); free_one(1); free_one(0);
        send_pkt(10, 31, 1'b1, -1);
        get_desc(d);
        chk_desc(d, 0, 10, 1);
        walk(0, 10, 31);
        free_one(0);
    endtask

    task automatic t_backpressure();
        logic [127:0] d;
        int low = 0;
        send_pkt(10, 40, 1'b1, -1);
        send_pkt(11, 41, 1'b1, -1);
        send_pkt(12, 42, 1'b1, -1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!in_ready) low++;
        end
        chk(low == 5, "R9 input stalled while queue full", low, 5);
        get_desc(d); chk_desc(d, 0, 10, 1);
        get_desc(d); chk_desc(d, 1, 11, 1);
        get_desc(d); chk_desc(d, 2, 12, 1);
        walk(2, 12, 42);
        free_one(2); free_one(1); free_one(0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_stray();
        t_short();
        t_multi();
        t_boundary();
        t_lifo();
        t_drop_ext();
        t_drop_onc();
        t_backpressure();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule